// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sequences a five-stage in-order pipeline (Fetch, Decode, Execute, Memory, Writeback) that carries simplified instructions. Each instruction has a two-bit type code and three register-number slots. The block tracks which stage each instruction occupies. Data values, address arithmetic and memory contents are not modelled. Operands are assumed to be forwarded, so the only dependency that forwarding cannot cover is a load whose destination is read by the instruction directly behind it. For that case the controller holds Fetch and Decode for a single cycle and sends an empty slot into Execute.

Upstream logic offers one instruction per cycle with `in_valid`. An offered instruction is taken at a clock edge only while `stall` is low. While `stall` is high, the offer must be kept on the inputs. Per-stage occupancy comes out on `stage_valid`, and `retire` marks each cycle in which an instruction completes Writeback, so cycle counts can be measured from outside.

Top module: `load_use_ctrl`

## Requirements
- R1: While reset is asserted (including a reset applied mid-run), `stage_valid` is all zero and `stall` and `retire` are low.
- R2: An instruction taken at clock edge k with no stall on its way retires in the cycle after edge k+4. Unstalled instructions retire in consecutive cycles, one per cycle. `stage_valid` bit 0 is Fetch, bit 1 Decode, bit 2 Execute, bit 3 Memory, bit 4 Writeback.
- R3: `stall` is high exactly when Decode holds a valid instruction that reads the destination of a valid load in Execute. It lasts one cycle per hazard, and the dependent instruction and everything behind it are delayed by exactly one cycle.
- R4: The slots read depend on the type code (`in_op`: 0 = R, 1 = I, 2 = L, 3 = S). R reads slots b and c. I reads slot b only (slot c carries immediate bits). L reads slot c only (slot b carries offset bits). S reads slots a and c. A match in a slot the type does not read causes no stall.
- R5: Only a load creates a hazard, and only against the next instruction in time. A dependency on an R, I or S instruction, or on a load that is two or more slots earlier, causes no stall.
- R6: Register number 0 gets no special treatment: a match on register 0 stalls like any other.
- R7: In the cycle after `stall` is high, Fetch and Decode occupancy are unchanged and Execute holds an empty slot. An input offered while `stall` is high is not taken.
- R8: `retire` is high for exactly one cycle per accepted valid instruction. This is the cycle after that instruction's cycle in Memory. Empty slots never retire.
- R9: A cycle with `in_valid` low inserts an empty slot. A load and a dependent instruction separated by such a slot do not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_op | input | 2 | Type code: 0 R, 1 I, 2 L, 3 S |
| in_fa | input | REG_W | Slot a: destination for R/I/L, data register for S |
| in_fb | input | REG_W | Slot b: source for R/I, offset bits for L/S |
| in_fc | input | REG_W | Slot c: source for R, immediate bits for I, base for L/S |
| stall | output | 1 | Load-use hold this cycle. The offered input is not taken |
| stage_valid | output | 5 | Occupancy per stage, bit 0 Fetch to bit 4 Writeback |
| retire | output | 1 | A valid instruction completes Writeback this cycle |

## Verification
A single program stream exercises the hazard check with a dependent read placed in each slot that each type actually reads. The same stream also puts matching register numbers in immediate and offset slots, which separates decoding of real source slots from plain field comparison. Dependencies at distance two, on stores and on non-load writers, and across an idle input cycle separate the single-adjacency rule from a broader scoreboard. Back-to-back stalls (a load depending on a load, then a store on that load) and a match on register 0 test that the stall releases after one cycle and that no register number is exempted. The stall cycle and the retire cycle of every instruction are predicted from a timing model, so a bubble that is misplaced or doubled shows up as a shifted retire.

// File: rtl/lu_pkg.sv
package lu_pkg;

  parameter int REG_W  = 5;
  parameter int NSRC   = 3;
  parameter int NSTAGE = 5;

  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [1:0] {
    OP_R = 2'd0,
    OP_I = 2'd1,
    OP_L = 2'd2,
    OP_S = 2'd3
  } op_e;

  typedef struct packed {
    logic vld;
    op_e  op;
    reg_t fa;
    reg_t fb;
    reg_t fc;
  } instr_t;

  // Compact record kept in Execute: only what the hazard check needs.
  typedef struct packed {
    logic vld;
    logic ld;
    reg_t dst;
  } xrec_t;

  // Bit 0 = slot a, bit 1 = slot b, bit 2 = slot c.
  function automatic logic [NSRC-1:0] src_slots(op_e op);
    logic [NSRC-1:0] m;
    unique case (op)
      OP_R:    m = 3'b110;
      OP_I:    m = 3'b010;
      OP_L:    m = 3'b100;
      default: m = 3'b101;
    endcase
    return m;
  endfunction

  function automatic logic is_load(op_e op);
    return op == OP_L;
  endfunction

endpackage

// File: rtl/lu_pipe_reg.sv
module lu_pipe_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         flush,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (flush) q <= '0;
    else if (!hold) q <= d;
  end

endmodule

// File: rtl/lu_operand_decode.sv
module lu_operand_decode
  import lu_pkg::*;
(
  input  instr_t          ins,
  output logic [NSRC-1:0] rd_en,
  output logic            ld
);

  always_comb begin
    rd_en = ins.vld ? src_slots(ins.op) : '0;
    ld    = ins.vld & is_load(ins.op);
  end

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_pkg::*;
(
  input  instr_t          dec,
  input  logic [NSRC-1:0] rd_en,
  input  xrec_t           ex,
  output logic [NSRC-1:0] hit,
  output logic            stall
);

  reg_t slot [NSRC];

  always_comb begin
    slot[0] = dec.fa;
    slot[1] = dec.fb;
    slot[2] = dec.fc;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_cmp
    assign hit[s] = rd_en[s] & (slot[s] == ex.dst);
  end

  assign stall = ex.vld & ex.ld & (|hit);

endmodule

// File: rtl/load_use_ctrl.sv
module load_use_ctrl
  import lu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [REG_W-1:0]  in_fa,
  input  logic [REG_W-1:0]  in_fb,
  input  logic [REG_W-1:0]  in_fc,
  output logic              stall,
  output logic [NSTAGE-1:0] stage_valid,
  output logic              retire
);

  localparam int NTAIL = NSTAGE - 3;
  localparam int IW    = $bits(instr_t);
  localparam int XW    = $bits(xrec_t);

  instr_t          in_ins, f_q, d_q;
  xrec_t           x_d, x_q;
  logic [NSRC-1:0] d_rd_en, hz_hit;
  logic            d_ld;
  logic [NTAIL-1:0] tail_q;

  always_comb begin
    in_ins.vld = in_valid;
    in_ins.op  = op_e'(in_op);
    in_ins.fa  = in_fa;
    in_ins.fb  = in_fb;
    in_ins.fc  = in_fc;
  end

  // Fetch and Decode hold during a load-use stall.
  lu_pipe_reg #(.W(IW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .hold(stall), .flush(1'b0), .d(in_ins), .q(f_q)
  );

  lu_pipe_reg #(.W(IW)) u_decode (
    .clk(clk), .rst_n(rst_n), .hold(stall), .flush(1'b0), .d(f_q), .q(d_q)
  );

  lu_operand_decode u_opdec (
    .ins(d_q), .rd_en(d_rd_en), .ld(d_ld)
  );

  lu_hazard_unit u_hazard (
    .dec(d_q), .rd_en(d_rd_en), .ex(x_q), .hit(hz_hit), .stall(stall)
  );

  always_comb begin
    x_d.vld = d_q.vld;
    x_d.ld  = d_ld;
    x_d.dst = d_q.fa;
  end

  // Execute takes a bubble during a stall.
  lu_pipe_reg #(.W(XW)) u_exec (
    .clk(clk), .rst_n(rst_n), .hold(1'b0), .flush(stall), .d(x_d), .q(x_q)
  );

  // Memory and Writeback only carry occupancy.
  for (genvar s = 0; s < NTAIL; s++) begin : g_tail
    logic nxt;
    if (s == 0) begin : g_first
      assign nxt = x_q.vld;
    end else begin : g_rest
      assign nxt = tail_q[s-1];
    end
    lu_pipe_reg #(.W(1)) u_stage (
      .clk(clk), .rst_n(rst_n), .hold(1'b0), .flush(1'b0), .d(nxt), .q(tail_q[s])
    );
  end

  assign stage_valid = {tail_q, x_q.vld, d_q.vld, f_q.vld};
  assign retire      = tail_q[NTAIL-1];

endmodule

// File: rtl/lu_ctrl_checker.sv
module lu_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [4:0] stage_valid,
  input logic       retire
);

  assert_stall_occupied_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stage_valid[1] && stage_valid[2]));

  assert_single_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  assert_bubble_into_ex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stage_valid[2]);

  assert_front_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (stage_valid[1:0] == $past(stage_valid[1:0])));

  assert_decode_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && stage_valid[1]) |=> stage_valid[2]);

  assert_retire_after_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[3] |=> retire);

  assert_no_bubble_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid[3] |=> !retire);

endmodule

bind load_use_ctrl lu_ctrl_checker u_lu_ctrl_checker (
  .clk(clk), .rst_n(rst_n), .stall(stall), .stage_valid(stage_valid), .retire(retire)
);

// File: tb/test_load_use_ctrl.sv
`timescale 1ns/1ps
module test_load_use_ctrl;

  localparam int RW    = 5;
  localparam int NROWS = 22;
  localparam int ROW_W = 19;
  localparam int MAXC  = 512;

  // Row: [18] valid, [17:16] op (0 R,1 I,2 L,3 S), [15:11] a, [10:6] b, [5:1] c, [0] stall expected in Decode
  localparam logic [ROW_W-1:0] PROG [NROWS] = '{
    {1'b1, 2'd2, 5'd3,  5'd0,  5'd4,  1'b0},  // load r3
    {1'b1, 2'd0, 5'd5,  5'd3,  5'd6,  1'b1},  // R reads r3 in slot b
    {1'b1, 2'd0, 5'd7,  5'd3,  5'd3,  1'b0},  // distance two
    {1'b1, 2'd2, 5'd8,  5'd1,  5'd2,  1'b0},  // load r8
    {1'b1, 2'd0, 5'd9,  5'd1,  5'd8,  1'b1},  // R reads r8 in slot c
    {1'b1, 2'd2, 5'd10, 5'd0,  5'd9,  1'b0},  // base from R: forwarded
    {1'b1, 2'd1, 5'd11, 5'd10, 5'd0,  1'b1},  // I reads r10 in slot b
    {1'b1, 2'd2, 5'd12, 5'd0,  5'd0,  1'b0},  // load r12
    {1'b1, 2'd1, 5'd13, 5'd1,  5'd12, 1'b0},  // I immediate bits match: ignored
    {1'b1, 2'd2, 5'd14, 5'd0,  5'd1,  1'b0},  // load r14
    {1'b1, 2'd2, 5'd15, 5'd14, 5'd2,  1'b0},  // L offset bits match: ignored
    {1'b1, 2'd2, 5'd16, 5'd0,  5'd15, 1'b1},  // load base from load
    {1'b1, 2'd3, 5'd16, 5'd0,  5'd3,  1'b1},  // store data from load
    {1'b1, 2'd2, 5'd0,  5'd0,  5'd5,  1'b0},  // load r0
    {1'b1, 2'd3, 5'd4,  5'd0,  5'd0,  1'b1},  // store base r0
    {1'b1, 2'd3, 5'd17, 5'd0,  5'd18, 1'b0},  // store
    {1'b1, 2'd0, 5'd19, 5'd17, 5'd18, 1'b0},  // after store: no stall
    {1'b1, 2'd2, 5'd20, 5'd0,  5'd1,  1'b0},  // load r20
    {1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  1'b0},  // idle slot
    {1'b1, 2'd0, 5'd21, 5'd20, 5'd20, 1'b0},  // across idle slot
    {1'b1, 2'd2, 5'd22, 5'd0,  5'd1,  1'b0},  // load r22
    {1'b1, 2'd0, 5'd23, 5'd1,  5'd2,  1'b0}   // unrelated
  };

  localparam string TAGS [NROWS] = '{
    "R5", "R3", "R5", "R5", "R4", "R5", "R4", "R5", "R4", "R5", "R4",
    "R3", "R4", "R5", "R6", "R5", "R5", "R5", "R9", "R9", "R5", "R5"
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = 2'd0;
  logic [RW-1:0] in_fa = '0, in_fb = '0, in_fc = '0;
  logic          stall, retire;
  logic [4:0]    stage_valid;

  load_use_ctrl i_load_use_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_fa(in_fa), .in_fb(in_fb), .in_fc(in_fc),
    .stall(stall), .stage_valid(stage_valid), .retire(retire)
  );

  always #2 clk = ~clk;

  int   n_run = 0;
  int   n_fail = 0;
  int   ecnt = 0;
  bit   done = 1'b0;
  bit   stall_at [MAXC];
  bit   ret_at   [MAXC];
  logic [4:0] sv_at [MAXC];
  int   acc      [NROWS];

  always @(posedge clk) ecnt <= ecnt + 1;

  always @(negedge clk) begin
    if (ecnt < MAXC) begin
      stall_at[ecnt] = stall;
      ret_at[ecnt]   = retire;
      sv_at[ecnt]    = stage_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int i);
    @(negedge clk);
    in_valid = PROG[i][18];
    in_op    = PROG[i][17:16];
    in_fa    = PROG[i][15:11];
    in_fb    = PROG[i][10:6];
    in_fc    = PROG[i][5:1];
    while (stall) @(negedge clk);
    acc[i] = ecnt + 1;
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int prev_x;
    int nvalid;
    int nret;
    int nstall;
    int exp_stalls;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(stage_valid == 5'd0 && !stall && !retire, "R1", int'(stage_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) send(i);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (14) @(negedge clk);

    prev_x = 0;
    nvalid = 0;
    exp_stalls = 0;
    for (int i = 0; i < NROWS; i++) begin
      int d;
      int x;
      int e;
      if (!PROG[i][18]) continue;
      nvalid++;
      e = int'(PROG[i][0]);
      exp_stalls += e;
      d = (acc[i] + 1 > prev_x) ? acc[i] + 1 : prev_x;
      x = d + 1 + e;
      // stall seen (or absent) while this row sits in Decode
      chk(stall_at[d] == PROG[i][0], TAGS[i], int'(stall_at[d]), e);
      if (e == 1) begin
        // R7: after the stall, Decode still occupied, Execute empty
        chk(sv_at[d+1][1] && !sv_at[d+1][2], "R7", int'(sv_at[d+1]), 2);
      end
      // R2: retire in the cycle after it reaches Writeback
      chk(ret_at[x+2], "R2", int'(ret_at[x+2]), 1);
      prev_x = x;
    end

    nret = 0;
    nstall = 0;
    for (int c = 0; c < ecnt && c < MAXC; c++) begin
      nret += int'(ret_at[c]);
      nstall += int'(stall_at[c]);
    end
    chk(nret == nvalid, "R8", nret, nvalid);
    chk(nstall == exp_stalls, "R3", nstall, exp_stalls);

    // R1: reset applied with the pipeline busy
    for (int i = 0; i < 3; i++) send(16);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(stage_valid == 5'd0 && !stall && !retire, "R1", int'(stage_valid), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(stage_valid == 5'd0 && !retire, "R1", int'(stage_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule